// File: doc/BRIEF.md
# CAN Transmit Buffer Priority Selector

This block decides which queued CAN transmit buffer goes out next. It keeps a small bank of transmit buffers. Each buffer has an 8-bit local priority and an empty flag. Software fills a buffer while its empty flag is set. It then writes a one to that flag bit, which clears the flag and queues the buffer. When the protocol engine is about to send a start-of-frame, it pulses a request. The block then compares the priorities of all queued buffers. On the next clock it presents the index of the winner together with a valid strobe.

A lower priority number means a more urgent frame. When two queued buffers hold equal values, the one with the lower index wins. The comparison uses the flag and priority state that is registered at the moment of the request. Any edit completed before that moment is therefore taken into account.

The CPU reaches one priority register at a time, through a one-hot buffer-select input. Access is granted only while the selected buffer is empty. When the engine reports that a frame is finished, the block sets the empty flag of the latched winner again.

Top module: `txPrioSel`

## Requirements
- R1: After reset every priority register reads as zero once it is accessible, `emptyFlags` is all ones, `winValid` is 0 and `winIdx` is 0.
- R2: On a start-of-frame request, the queued buffer with the numerically smallest priority is chosen.
- R3: When several queued buffers share the smallest priority, the lowest index among them is chosen.
- R4: Only buffers whose `emptyFlags` bit is 0 take part in the comparison. An empty buffer never wins, whatever its priority.
- R5: A priority write with `cpuWrEn` high takes effect only when `cpuSel` is exactly one-hot and the selected buffer's empty flag is 1. In every other case the register keeps its value.
- R6: `cpuRdData` shows the selected buffer's priority, combinationally, under the same condition as R5. Otherwise it is zero.
- R7: `winIdx` and `winValid` change on the clock edge at which `sofReq` is high. They use the flags and priorities held in registers just before that edge. A flag write made in the same cycle as the request is not seen; a flag write made one cycle earlier is.
- R8: A request with no buffer queued drives `winValid` to 0 and leaves `winIdx` unchanged.
- R9: `winIdx` and `winValid` hold their values until the next request.
- R10: With `flagWrEn` high, each one bit in `flagWrData` clears the matching empty flag. Zero bits have no effect. Empty flags are never cleared in any other way.
- R11: A `txDone` pulse while `winValid` is 1 sets the empty flag of buffer `winIdx`. In the same cycle it takes precedence over a CPU clear of that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuSel | input | NUM_BUF | One-hot selection of the buffer the CPU window maps to |
| cpuWrEn | input | 1 | Priority register write strobe |
| cpuWrData | input | PRIO_W | Priority write data |
| cpuRdData | output | PRIO_W | Priority read data (zero when access is denied) |
| flagWrEn | input | 1 | Empty-flag write strobe (write one to clear) |
| flagWrData | input | NUM_BUF | Empty-flag write data |
| emptyFlags | output | NUM_BUF | Empty flag per buffer (1 = empty, 0 = queued) |
| sofReq | input | 1 | Start-of-frame request from the protocol engine |
| txDone | input | 1 | Transmission of the current winner has completed |
| winIdx | output | IDX_W | Index of the latched winner |
| winValid | output | 1 | Latched winner is valid |

## Verification
The bench builds the block with its defaults: three buffers and 8-bit priorities. With three buffers, every pending mask from all-empty to all-queued can be reached. Ties can be set up between any two of the three positions. The priority extremes 0, 254 and 255 are also covered. A vector table and a randomised pass are compared against a reference model. They cover the full mask space, including the case where an empty buffer holds the smallest value. Directed sequences exercise the access gating, the same-cycle ordering of a flag write against a request, and the completion path.

// File: rtl/txprio_pkg.sv
package txprio_pkg;
  // Strobes issued by the control half to the datapath half.
  typedef struct packed {
    logic prioWr;   // write cpuWrData into the addressed priority register
    logic rdOk;     // read of the addressed priority register is allowed
    logic sofHit;   // start-of-frame arbitration sample
  } ctrlStrb_t;
endpackage

// File: rtl/txprio_ctrl.sv
module txprio_ctrl
  import txprio_pkg::*;
#(
  parameter int NUM_BUF = 3,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_BUF-1:0] cpuSel,
  input  logic               cpuWrEn,
  input  logic               flagWrEn,
  input  logic [NUM_BUF-1:0] flagWrData,
  input  logic               sofReq,
  input  logic               txDone,
  input  logic [IDX_W-1:0]   winIdx,
  input  logic               winValid,
  output logic [NUM_BUF-1:0] emptyFlags,
  output logic [IDX_W-1:0]   accIdx,
  output ctrlStrb_t          strb
);

  logic selOneHot;
  logic accOk;

  // Decode the one-hot window select into a buffer index.
  always_comb begin
    accIdx = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (cpuSel[i]) accIdx = IDX_W'(i);
    end
  end

  assign selOneHot   = $onehot(cpuSel);
  assign accOk       = selOneHot && emptyFlags[accIdx];
  assign strb.prioWr = accOk && cpuWrEn;
  assign strb.rdOk   = accOk;
  assign strb.sofHit = sofReq;

  // Empty flags: written one clears, completion of the winner sets.
  generate
    for (genvar g = 0; g < NUM_BUF; g++) begin : gFlag
      logic doneHit;
      assign doneHit = txDone && winValid && (winIdx == IDX_W'(g));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                        emptyFlags[g] <= 1'b1;
        else if (doneHit)                 emptyFlags[g] <= 1'b1;
        else if (flagWrEn && flagWrData[g]) emptyFlags[g] <= 1'b0;
      end

      // R10: a flag only drops after a CPU write-one to its bit
      a_r10_clear_only_by_cpu : assert property (@(posedge clk) disable iff (!rstN)
        $fell(emptyFlags[g]) |-> $past(flagWrEn && flagWrData[g]));
    end
  endgenerate

  // R11: completion of the latched winner frees its buffer
  a_r11_done_sets_flag : assert property (@(posedge clk) disable iff (!rstN)
    (txDone && winValid) |=> emptyFlags[$past(winIdx)]);

  // R5: a priority write strobe only ever reaches an empty buffer
  a_r5_write_needs_empty : assert property (@(posedge clk) disable iff (!rstN)
    strb.prioWr |=> emptyFlags[$past(accIdx)]);

endmodule

// File: rtl/txprio_datapath.sv
module txprio_datapath
  import txprio_pkg::*;
#(
  parameter int NUM_BUF = 3,
  parameter int PRIO_W  = 8,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [IDX_W-1:0]   accIdx,
  input  logic [PRIO_W-1:0]  cpuWrData,
  input  logic [NUM_BUF-1:0] pendingVec,
  output logic [PRIO_W-1:0]  cpuRdData,
  output logic [IDX_W-1:0]   winIdx,
  output logic               winValid
);

  logic [PRIO_W-1:0] prioArr [NUM_BUF];
  logic [IDX_W-1:0]  bestIdx;
  logic [PRIO_W-1:0] bestPrio;
  logic              anyPend;

  // Priority registers, one per buffer.
  generate
    for (genvar g = 0; g < NUM_BUF; g++) begin : gPrio
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                         prioArr[g] <= '0;
        else if (strb.prioWr && (accIdx == IDX_W'(g)))     prioArr[g] <= cpuWrData;
      end

      // R5: a register not addressed by a granted write keeps its value
      a_r5_prio_stable : assert property (@(posedge clk) disable iff (!rstN)
        !(strb.prioWr && (accIdx == IDX_W'(g))) |=> $stable(prioArr[g]));

      // R2/R3: the latched winner beats or ties-with-lower-index every queued entrant
      a_r2_winner_min : assert property (@(posedge clk) disable iff (!rstN)
        (strb.sofHit && pendingVec[g]) |=>
          winValid && ((prioArr[winIdx] < $past(prioArr[g])) ||
                       ((prioArr[winIdx] == $past(prioArr[g])) && (winIdx <= IDX_W'(g)))));
    end
  endgenerate

  assign cpuRdData = strb.rdOk ? prioArr[accIdx] : '0;

  // Linear scan: strict less-than keeps the lower index on a tie.
  always_comb begin
    bestIdx  = '0;
    bestPrio = '1;
    anyPend  = 1'b0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (pendingVec[i] && (!anyPend || (prioArr[i] < bestPrio))) begin
        bestIdx  = IDX_W'(i);
        bestPrio = prioArr[i];
        anyPend  = 1'b1;
      end
    end
  end

  // Winner latch.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winIdx   <= '0;
      winValid <= 1'b0;
    end else if (strb.sofHit) begin
      winValid <= anyPend;
      if (anyPend) winIdx <= bestIdx;
    end
  end

  // R4: the latched winner was queued at the request
  a_r4_winner_pending : assert property (@(posedge clk) disable iff (!rstN)
    (strb.sofHit && (pendingVec != '0)) |=> (($past(pendingVec) >> winIdx) & 1'b1) == 1'b1);

  // R8: an empty request clears valid and keeps the index
  a_r8_none_pending : assert property (@(posedge clk) disable iff (!rstN)
    (strb.sofHit && (pendingVec == '0)) |=> !winValid && $stable(winIdx));

  // R9: outputs hold between requests
  a_r9_hold : assert property (@(posedge clk) disable iff (!rstN)
    !strb.sofHit |=> $stable(winIdx) && $stable(winValid));

  // R6: a denied read returns zero
  a_r6_denied_read_zero : assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdOk |-> (cpuRdData == '0));

endmodule

// File: rtl/txPrioSel.sv
module txPrioSel
  import txprio_pkg::*;
#(
  parameter int NUM_BUF = 3,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_BUF-1:0] cpuSel,
  input  logic               cpuWrEn,
  input  logic [PRIO_W-1:0]  cpuWrData,
  output logic [PRIO_W-1:0]  cpuRdData,
  input  logic               flagWrEn,
  input  logic [NUM_BUF-1:0] flagWrData,
  output logic [NUM_BUF-1:0] emptyFlags,
  input  logic               sofReq,
  input  logic               txDone,
  output logic [IDX_W-1:0]   winIdx,
  output logic               winValid
);

  ctrlStrb_t        strb;
  logic [IDX_W-1:0] accIdx;

  txprio_ctrl #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWrEn(cpuWrEn),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData), .sofReq(sofReq),
    .txDone(txDone), .winIdx(winIdx), .winValid(winValid),
    .emptyFlags(emptyFlags), .accIdx(accIdx), .strb(strb)
  );

  txprio_datapath #(.NUM_BUF(NUM_BUF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .accIdx(accIdx),
    .cpuWrData(cpuWrData), .pendingVec(~emptyFlags),
    .cpuRdData(cpuRdData), .winIdx(winIdx), .winValid(winValid)
  );

endmodule

// File: tb/sim_txPrioSel.sv
module sim_txPrioSel;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] cpuSel = '0;
  logic       cpuWrEn = 1'b0;
  logic [7:0] cpuWrData = '0;
  logic [7:0] cpuRdData;
  logic       flagWrEn = 1'b0;
  logic [2:0] flagWrData = '0;
  logic [2:0] emptyFlags;
  logic       sofReq = 1'b0;
  logic       txDone = 1'b0;
  logic [1:0] winIdx;
  logic       winValid;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  txPrioSel u0 (.*);

  // p0, p1, p2, queued mask (bit i = buffer i queued), expValid, expIdx
  localparam logic [29:0] VEC [10] = '{
    {8'd10,  8'd20,  8'd30,  3'b111, 1'b1, 2'd0},
    {8'd30,  8'd20,  8'd10,  3'b111, 1'b1, 2'd2},
    {8'd5,   8'd5,   8'd5,   3'b111, 1'b1, 2'd0},
    {8'd9,   8'd3,   8'd3,   3'b111, 1'b1, 2'd1},
    {8'd0,   8'd0,   8'd0,   3'b000, 1'b0, 2'd0},
    {8'd1,   8'd200, 8'd0,   3'b011, 1'b1, 2'd0},
    {8'd255, 8'd255, 8'd254, 3'b110, 1'b1, 2'd2},
    {8'd7,   8'd7,   8'd8,   3'b110, 1'b1, 2'd1},
    {8'd0,   8'd255, 8'd0,   3'b100, 1'b1, 2'd2},
    {8'd200, 8'd100, 8'd100, 3'b101, 1'b1, 2'd2}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writePrio(input int b, input logic [7:0] v);
    cpuSel = 3'(1 << b); cpuWrEn = 1'b1; cpuWrData = v;
    @(negedge clk);
    cpuWrEn = 1'b0; cpuSel = '0;
  endtask

  task automatic clearFlags(input logic [2:0] m);
    flagWrEn = 1'b1; flagWrData = m;
    @(negedge clk);
    flagWrEn = 1'b0; flagWrData = '0;
  endtask

  task automatic fireSof();
    sofReq = 1'b1;
    @(negedge clk);
    sofReq = 1'b0;
  endtask

  task automatic pulseDone();
    txDone = 1'b1;
    @(negedge clk);
    txDone = 1'b0;
  endtask

  function automatic logic [2:0] refWin(input logic [7:0] p0, input logic [7:0] p1,
                                        input logic [7:0] p2, input logic [2:0] q);
    logic [7:0] pa [3];
    logic       f;
    logic [1:0] bi;
    logic [7:0] bp;
    pa[0] = p0; pa[1] = p1; pa[2] = p2;
    f = 1'b0; bi = '0; bp = '0;
    for (int i = 0; i < 3; i++) begin
      if (q[i] && (!f || pa[i] < bp)) begin
        f = 1'b1; bi = 2'(i); bp = pa[i];
      end
    end
    return {f, bi};
  endfunction

  task automatic runCase(input string tag, input logic [7:0] p0, input logic [7:0] p1,
                         input logic [7:0] p2, input logic [2:0] q, input logic [2:0] exp);
    doReset();
    writePrio(0, p0); writePrio(1, p1); writePrio(2, p2);
    if (q != 3'b000) clearFlags(q);
    fireSof();
    check(tag, {29'd0, winValid, winIdx}, {29'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1 reset state
    doReset();
    check("R1 flags", 32'(emptyFlags), 32'h7);
    check("R1 valid", 32'(winValid), 32'h0);
    check("R1 idx", 32'(winIdx), 32'h0);
    cpuSel = 3'b100; #1;
    check("R1 prio zero", 32'(cpuRdData), 32'h0);
    cpuSel = '0;

    // R2/R3/R4 vector table
    foreach (VEC[k]) begin
      runCase("R2 R3 R4 table", VEC[k][29:22], VEC[k][21:14], VEC[k][13:6],
              VEC[k][5:3], VEC[k][2:0]);
    end

    // R2 R3 R4 random against the reference model, with forced ties
    for (int n = 0; n < 40; n++) begin
      logic [7:0] a, b, c;
      logic [2:0] q;
      a = 8'($urandom_range(0, 7));
      b = (n % 3 == 0) ? a : 8'($urandom_range(0, 7));
      c = 8'($urandom);
      q = 3'($urandom);
      runCase("R2 R3 R4 random", a, b, c, q, refWin(a, b, c, q));
    end

    // R5/R6/R10 access gating
    doReset();
    writePrio(1, 8'h40);
    cpuSel = 3'b010; #1;
    check("R6 read granted", 32'(cpuRdData), 32'h40);
    cpuSel = '0;
    clearFlags(3'b010);
    check("R10 clear one", 32'(emptyFlags), 32'h5);
    clearFlags(3'b000);
    check("R10 zero no effect", 32'(emptyFlags), 32'h5);
    writePrio(1, 8'h55);
    cpuSel = 3'b010; #1;
    check("R6 read denied while queued", 32'(cpuRdData), 32'h0);
    cpuSel = 3'b101; cpuWrEn = 1'b1; cpuWrData = 8'h77;
    #1;
    check("R6 read denied non-onehot", 32'(cpuRdData), 32'h0);
    @(negedge clk);
    cpuWrEn = 1'b0; cpuSel = 3'b001; #1;
    check("R5 non-onehot write ignored", 32'(cpuRdData), 32'h0);
    cpuSel = '0;

    // R4/R9/R11 single queued buffer, hold, completion
    fireSof();
    check("R4 lone queued", {30'd0, winValid, winIdx[0]}, 32'h3);
    repeat (3) @(negedge clk);
    check("R9 hold", {29'd0, winValid, winIdx}, 32'h5);
    pulseDone();
    check("R11 done sets flag", 32'(emptyFlags), 32'h7);
    check("R9 valid held after done", 32'(winValid), 32'h1);
    cpuSel = 3'b010; #1;
    check("R5 queued write ignored", 32'(cpuRdData), 32'h40);
    cpuSel = '0;

    // R8 no queued buffer
    fireSof();
    check("R8 valid low", 32'(winValid), 32'h0);
    check("R8 idx kept", 32'(winIdx), 32'h1);

    // R7 sampling instant
    doReset();
    writePrio(0, 8'd50);
    writePrio(2, 8'd20);
    clearFlags(3'b001);
    flagWrEn = 1'b1; flagWrData = 3'b100; sofReq = 1'b1;
    @(negedge clk);
    flagWrEn = 1'b0; flagWrData = '0; sofReq = 1'b0;
    check("R7 same-cycle clear unseen", {29'd0, winValid, winIdx}, 32'h4);
    fireSof();
    check("R7 earlier clear seen", {29'd0, winValid, winIdx}, 32'h6);

    // R11 completion beats a same-cycle clear
    txDone = 1'b1; flagWrEn = 1'b1; flagWrData = 3'b100;
    @(negedge clk);
    txDone = 1'b0; flagWrEn = 1'b0; flagWrData = '0;
    check("R11 done precedence", 32'(emptyFlags[2]), 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule